// File: doc/BRIEF.md
# Asynchronous SRAM cycle controller

This block sits between a synchronous request port and an external asynchronous static RAM organised as 512K words of 8 bits. Each accepted request becomes one complete memory cycle. A read or a write is carried out by sequencing three active-low strobes: chip select, output enable and write enable. The address and the write data are held steady on the memory pins for the whole of that cycle. Read data comes back on a one-cycle response pulse.

Every interval in the cycle is a whole number of controller clocks. The block derives these counts at elaboration time from two parameters: the clock period in nanoseconds and a speed-grade index from 0 to 3. The grades select 20, 25, 35 or 45 ns memory parts. Each count is the required time divided by the clock period and rounded up, with a floor of one cycle. Writes are ended by the write-enable edge while chip select stays low. The controller never drives the data pins until the memory's outputs have had their full float time since output enable was last released. With no work pending, chip select returns high and the memory is in standby.

Top module: `sram_seq_ctrl`

## Requirements
- R1: While `rst_n` is low, `mem_cs_n`, `mem_oe_n` and `mem_we_n` are all 1 and `mem_dq_oe` is 0.
- R2: Whenever the controller is idle (`req_ready` = 1), `mem_cs_n` is 1 and `mem_dq_oe` is 0.
- R3: A read (`req_write` = 0) holds `mem_cs_n` = 0, `mem_oe_n` = 0 and `mem_we_n` = 1 for exactly N_RD cycles. N_RD is the larger of the address-access time and the output-enable access time, converted to cycles. The value on `mem_dq_in` at the last edge of that window is returned on `resp_rdata`, with `resp_valid` high in the following cycle.
- R4: A write (`req_write` = 1) keeps `mem_cs_n` = 0 around a single `mem_we_n` low pulse of exactly N_WP cycles. N_WP is the larger of the minimum write-pulse width and the data-setup time, converted to cycles.
- R5: Write data is driven (`mem_dq_oe` = 1) for exactly N_AS cycles before `mem_we_n` falls and for exactly N_HOLD cycles after it rises. N_AS is 2 ns converted to cycles. N_HOLD is the larger of 2 ns converted to cycles and the remainder needed to reach the write cycle time. `mem_addr` and `mem_dq_out` do not change while chip select or the data drive is active.
- R6: `mem_dq_oe` rises only after `mem_oe_n` has been 1 for at least N_REL consecutive cycles. N_REL is the larger of the output-enable and chip-select float times, converted to cycles.
- R7: `req_ready` is 1 only while idle. A request that is held while `req_ready` is 0 is taken only once `req_ready` returns to 1, and is neither lost nor duplicated. `resp_valid` is a single-cycle pulse, one per request, in request order.
- R8: Grade 0..3 selects access times of 20/25/35/45 ns and output-enable access times of 10/10/25/35 ns. It also selects write pulses of 16/20/25/30 ns, data setups of 15/15/20/25 ns, write cycles of 20/25/35/45 ns, output-enable float times of 12/15/20/25 ns and chip-select float times of 15/17/20/30 ns. Each becomes ceil(ns / CLK_PERIOD_NS) cycles, with a minimum of 1.
- R9: `mem_oe_n` and `mem_we_n` are never low together, and `mem_dq_oe` is never 1 while `mem_oe_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (19) | Word address |
| req_wdata | input | DATA_W (8) | Write data |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | DATA_W (8) | Read data, valid with `resp_valid` after a read |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | ADDR_W (19) | Memory address pins |
| mem_dq_out | output | DATA_W (8) | Value for the data pins when driven |
| mem_dq_oe | output | 1 | Drive enable for the data pins |
| mem_dq_in | input | DATA_W (8) | Value read from the data pins |

## Verification
A wrong phase count shows up at the strobe pins within the same memory cycle. A write pulse, read window, setup or hold interval that is one cycle short or long can be seen on the very next strobe edge. A release counter that expires early shows up as a data drive starting too soon after a read, on the first write that follows one. A phase machine stuck out of idle keeps `req_ready` low, so the queued requests never receive their responses. A mis-latched address or captured byte shows up only when the scoreboard compares `resp_rdata` with its shadow copy on a later read of the same location.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_READ   = 3'd1,
    PH_WTURN  = 3'd2,
    PH_WSETUP = 3'd3,
    PH_WPULSE = 3'd4,
    PH_WHOLD  = 3'd5
  } phase_e;

  localparam int unsigned ADDR_SETUP_NS = 2;
  localparam int unsigned ADDR_HOLD_NS  = 2;
  localparam int unsigned DATA_HOLD_NS  = 1;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // ceil(ns / period), never below one cycle
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
    int unsigned c;
    c = (per == 0) ? ns : (ns + per - 1) / per;
    return (c == 0) ? 1 : c;
  endfunction

  // grade tables (ns)
  function automatic int unsigned gr_access(input int unsigned g);
    case (g)
      0: return 20;
      1: return 25;
      2: return 35;
      default: return 45;
    endcase
  endfunction

  function automatic int unsigned gr_oe_valid(input int unsigned g);
    case (g)
      0: return 10;
      1: return 10;
      2: return 25;
      default: return 35;
    endcase
  endfunction

  function automatic int unsigned gr_we_width(input int unsigned g);
    case (g)
      0: return 16;
      1: return 20;
      2: return 25;
      default: return 30;
    endcase
  endfunction

  function automatic int unsigned gr_data_setup(input int unsigned g);
    case (g)
      0: return 15;
      1: return 15;
      2: return 20;
      default: return 25;
    endcase
  endfunction

  function automatic int unsigned gr_wr_cycle(input int unsigned g);
    return gr_access(g);
  endfunction

  function automatic int unsigned gr_oe_float(input int unsigned g);
    case (g)
      0: return 12;
      1: return 15;
      2: return 20;
      default: return 25;
    endcase
  endfunction

  function automatic int unsigned gr_cs_float(input int unsigned g);
    case (g)
      0: return 15;
      1: return 17;
      2: return 20;
      default: return 30;
    endcase
  endfunction

  // phase lengths in cycles
  function automatic int unsigned rd_cycles(input int unsigned g, input int unsigned per);
    return ns_to_cyc(max_u(gr_access(g), gr_oe_valid(g)), per);
  endfunction

  function automatic int unsigned wp_cycles(input int unsigned g, input int unsigned per);
    return ns_to_cyc(max_u(gr_we_width(g), gr_data_setup(g)), per);
  endfunction

  function automatic int unsigned as_cycles(input int unsigned per);
    return ns_to_cyc(ADDR_SETUP_NS, per);
  endfunction

  function automatic int unsigned hold_cycles(input int unsigned g, input int unsigned per);
    int unsigned base;
    int unsigned used;
    int unsigned wc;
    base = ns_to_cyc(max_u(ADDR_HOLD_NS, DATA_HOLD_NS), per);
    used = as_cycles(per) + wp_cycles(g, per);
    wc   = ns_to_cyc(gr_wr_cycle(g), per);
    return (wc > used) ? max_u(base, wc - used) : base;
  endfunction

  function automatic int unsigned rel_cycles(input int unsigned g, input int unsigned per);
    return ns_to_cyc(max_u(gr_oe_float(g), gr_cs_float(g)), per);
  endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (ld)             cnt_q <= ld_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_seq_pkg::*;
#(
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned N_RD   = 2,
  parameter int unsigned N_AS   = 1,
  parameter int unsigned N_WP   = 2,
  parameter int unsigned N_HOLD = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             ph_expired,
  input  logic             bus_busy,
  output phase_e           phase,
  output logic             ph_ld,
  output logic [CNT_W-1:0] ph_ld_val,
  output logic             accept,
  output logic             rd_capture,
  output logic             wr_finish
);
  localparam logic [CNT_W-1:0] LD_RD   = CNT_W'(N_RD - 1);
  localparam logic [CNT_W-1:0] LD_AS   = CNT_W'(N_AS - 1);
  localparam logic [CNT_W-1:0] LD_WP   = CNT_W'(N_WP - 1);
  localparam logic [CNT_W-1:0] LD_HOLD = CNT_W'(N_HOLD - 1);

  phase_e nxt;

  always_comb begin
    nxt        = phase;
    ph_ld      = 1'b0;
    ph_ld_val  = '0;
    accept     = 1'b0;
    rd_capture = 1'b0;
    wr_finish  = 1'b0;
    case (phase)
      PH_IDLE: begin
        if (req_valid) begin
          accept = 1'b1;
          ph_ld  = 1'b1;
          if (req_write) begin
            nxt       = PH_WTURN;
            ph_ld_val = '0;
          end else begin
            nxt       = PH_READ;
            ph_ld_val = LD_RD;
          end
        end
      end
      PH_READ: begin
        if (ph_expired) begin
          rd_capture = 1'b1;
          nxt        = PH_IDLE;
        end
      end
      PH_WTURN: begin
        if (!bus_busy) begin
          nxt       = PH_WSETUP;
          ph_ld     = 1'b1;
          ph_ld_val = LD_AS;
        end
      end
      PH_WSETUP: begin
        if (ph_expired) begin
          nxt       = PH_WPULSE;
          ph_ld     = 1'b1;
          ph_ld_val = LD_WP;
        end
      end
      PH_WPULSE: begin
        if (ph_expired) begin
          nxt       = PH_WHOLD;
          ph_ld     = 1'b1;
          ph_ld_val = LD_HOLD;
        end
      end
      PH_WHOLD: begin
        if (ph_expired) begin
          wr_finish = 1'b1;
          nxt       = PH_IDLE;
        end
      end
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= nxt;
  end
endmodule

// File: rtl/sram_seq_datapath.sv
module sram_seq_datapath #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              rd_capture,
  input  logic              wr_finish,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              done_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rdata_q <= '0;
    else if (rd_capture) rdata_q <= mem_dq_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= rd_capture | wr_finish;
  end
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned GRADE         = 0,
  parameter int unsigned ADDR_W        = 19,
  parameter int unsigned DATA_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int unsigned N_RD   = rd_cycles(GRADE, CLK_PERIOD_NS);
  localparam int unsigned N_AS   = as_cycles(CLK_PERIOD_NS);
  localparam int unsigned N_WP   = wp_cycles(GRADE, CLK_PERIOD_NS);
  localparam int unsigned N_HOLD = hold_cycles(GRADE, CLK_PERIOD_NS);
  localparam int unsigned N_REL  = rel_cycles(GRADE, CLK_PERIOD_NS);
  localparam int unsigned N_MAX  = max_u(max_u(N_RD, N_REL), max_u(max_u(N_AS, N_WP), N_HOLD));
  localparam int unsigned CNT_W  = $clog2(N_MAX + 1);

  // named internal events
  phase_e           phase;
  logic             ph_ld;
  logic [CNT_W-1:0] ph_ld_val;
  logic             ph_expired;
  logic             rel_idle;
  logic             bus_busy;
  logic             accept;
  logic             rd_capture;
  logic             wr_finish;
  logic             bus_drive;
  logic             in_cycle;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  sram_seq_fsm #(
    .CNT_W (CNT_W),
    .N_RD  (N_RD),
    .N_AS  (N_AS),
    .N_WP  (N_WP),
    .N_HOLD(N_HOLD)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .ph_expired(ph_expired),
    .bus_busy  (bus_busy),
    .phase     (phase),
    .ph_ld     (ph_ld),
    .ph_ld_val (ph_ld_val),
    .accept    (accept),
    .rd_capture(rd_capture),
    .wr_finish (wr_finish)
  );

  // phase length counter
  sram_seq_timer #(.CNT_W(CNT_W)) u_phase_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (ph_ld),
    .ld_val (ph_ld_val),
    .expired(ph_expired)
  );

  // output float counter, started when output enable is released
  sram_seq_timer #(.CNT_W(CNT_W)) u_float_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (rd_capture),
    .ld_val (CNT_W'(N_REL)),
    .expired(rel_idle)
  );
  assign bus_busy = !rel_idle;

  sram_seq_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rd_capture(rd_capture),
    .wr_finish (wr_finish),
    .mem_dq_in (mem_dq_in),
    .addr_q    (addr_q),
    .wdata_q   (wdata_q),
    .rdata_q   (resp_rdata),
    .done_q    (resp_valid)
  );

  // strobe decode from the registered phase
  assign in_cycle   = (phase != PH_IDLE);
  assign bus_drive  = (phase == PH_WSETUP) || (phase == PH_WPULSE) || (phase == PH_WHOLD);
  assign req_ready  = !in_cycle;
  assign mem_cs_n   = !in_cycle;
  assign mem_oe_n   = (phase != PH_READ);
  assign mem_we_n   = (phase != PH_WPULSE);
  assign mem_addr   = addr_q;
  assign mem_dq_oe  = bus_drive;
  assign mem_dq_out = bus_drive ? wdata_q : '0;
endmodule

// File: rtl/sram_seq_ctrl_chk.sv
module sram_seq_ctrl_chk
  import sram_seq_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned GRADE         = 0,
  parameter int unsigned ADDR_W        = 19,
  parameter int unsigned DATA_W        = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              resp_valid,
  input logic              mem_cs_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe,
  input logic              rd_capture
);
  localparam logic [7:0] C_RD  = 8'(rd_cycles(GRADE, CLK_PERIOD_NS));
  localparam logic [7:0] C_WP  = 8'(wp_cycles(GRADE, CLK_PERIOD_NS));
  localparam logic [7:0] C_REL = 8'(rel_cycles(GRADE, CLK_PERIOD_NS));

  logic [7:0] oe_hi_cnt, oe_lo_cnt, we_lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_hi_cnt <= 8'hFF;
      oe_lo_cnt <= '0;
      we_lo_cnt <= '0;
    end else begin
      oe_hi_cnt <= mem_oe_n ? ((oe_hi_cnt == 8'hFF) ? oe_hi_cnt : oe_hi_cnt + 8'd1) : '0;
      oe_lo_cnt <= mem_oe_n ? '0 : ((oe_lo_cnt == 8'hFF) ? oe_lo_cnt : oe_lo_cnt + 8'd1);
      we_lo_cnt <= mem_we_n ? '0 : ((we_lo_cnt == 8'hFF) ? we_lo_cnt : we_lo_cnt + 8'd1);
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_STROBES_HIGH: assert (mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe); // R1
    end
  end

  AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && !mem_dq_oe)); // R2

  AST_READ_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (oe_lo_cnt >= C_RD)); // R3

  AST_CAPTURE_UNDER_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture |-> (!mem_cs_n && !mem_oe_n && mem_we_n)); // R3

  AST_WE_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_cs_n); // R4

  AST_WE_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_lo_cnt >= C_WP)); // R4

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)); // R5

  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out)); // R5

  AST_DRIVE_AFTER_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (oe_hi_cnt >= C_REL)); // R6

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> !req_ready); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid); // R7

  AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n)); // R9

  AST_NO_DRIVE_INTO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n); // R9
endmodule

bind sram_seq_ctrl sram_seq_ctrl_chk #(
  .CLK_PERIOD_NS(CLK_PERIOD_NS),
  .GRADE        (GRADE),
  .ADDR_W       (ADDR_W),
  .DATA_W       (DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .resp_valid(resp_valid),
  .mem_cs_n  (mem_cs_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_addr  (mem_addr),
  .mem_dq_out(mem_dq_out),
  .mem_dq_oe (mem_dq_oe),
  .rd_capture(rd_capture)
);

// File: tb/sram_seq_ctrl_tb_top.sv
module sram_seq_ctrl_tb_top;
  localparam int TB_CLK_NS = 8;
  localparam int TB_GRADE  = 1;
  localparam int WD_CYC    = 20000;

  // expected interval lengths restated from the timing tables
  localparam int ACC_NS [4] = '{20, 25, 35, 45};
  localparam int OEV_NS [4] = '{10, 10, 25, 35};
  localparam int WEW_NS [4] = '{16, 20, 25, 30};
  localparam int DSU_NS [4] = '{15, 15, 20, 25};
  localparam int OEF_NS [4] = '{12, 15, 20, 25};
  localparam int CSF_NS [4] = '{15, 17, 20, 30};

  function automatic int up_cyc(input int ns);
    int c;
    c = ns / TB_CLK_NS + ((ns % TB_CLK_NS) != 0 ? 1 : 0);
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int bigger(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int EXP_RD   = up_cyc(bigger(ACC_NS[TB_GRADE], OEV_NS[TB_GRADE]));
  localparam int EXP_WP   = up_cyc(bigger(WEW_NS[TB_GRADE], DSU_NS[TB_GRADE]));
  localparam int EXP_AS   = up_cyc(2);
  localparam int EXP_WC   = up_cyc(ACC_NS[TB_GRADE]);
  localparam int EXP_HOLD = bigger(up_cyc(2), EXP_WC - EXP_AS - EXP_WP);
  localparam int EXP_REL  = up_cyc(bigger(OEF_NS[TB_GRADE], CSF_NS[TB_GRADE]));

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        resp_valid;
  logic [7:0]  resp_rdata;
  logic        mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [18:0] mem_addr;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in;

  always #(TB_CLK_NS/2) clk = ~clk;

  sram_seq_ctrl #(
    .CLK_PERIOD_NS(TB_CLK_NS),
    .GRADE        (TB_GRADE),
    .ADDR_W       (19),
    .DATA_W       (8)
  ) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .resp_valid(resp_valid),
    .resp_rdata(resp_rdata),
    .mem_cs_n  (mem_cs_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_addr  (mem_addr),
    .mem_dq_out(mem_dq_out),
    .mem_dq_oe (mem_dq_oe),
    .mem_dq_in (mem_dq_in)
  );

  // ---------------- memory model ----------------
  logic [7:0] dev_mem [logic [18:0]];
  logic [7:0] dev_out = 8'h00;

  always @(mem_cs_n or mem_oe_n or mem_we_n or mem_addr) begin
    if (!mem_cs_n && !mem_oe_n && mem_we_n)
      dev_out = dev_mem.exists(mem_addr) ? dev_mem[mem_addr] : 8'hEE;
    else
      dev_out = 8'h00;
  end
  assign mem_dq_in = dev_out;

  always @(posedge mem_we_n) begin
    if (!mem_cs_n && mem_dq_oe) dev_mem[mem_addr] = mem_dq_out;
  end

  // ---------------- bookkeeping ----------------
  int n_chk = 0;
  int n_err = 0;
  int n_req = 0;
  int n_resp = 0;
  int held_cycles = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic        wr;
    logic [18:0] a;
    logic [7:0]  d;
  } item_t;
  item_t      sb_q[$];
  logic [7:0] shadow [logic [18:0]];

  // driver: presents a request, waits for acceptance, pushes the expectation
  task automatic do_req(input bit wr, input logic [18:0] a, input logic [7:0] d);
    item_t it;
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    while (!req_ready) begin
      held_cycles++;
      @(negedge clk);
    end
    it.wr = wr;
    it.a  = a;
    if (wr) begin
      it.d = d;
      shadow[a] = d;
    end else begin
      it.d = shadow.exists(a) ? shadow[a] : 8'hEE;
    end
    sb_q.push_back(it);
    n_req++;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: pops and compares on each response
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      n_resp++;
      if (sb_q.size() == 0) begin
        check(1'b0, "R7", "response with nothing outstanding", 1, 0);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        if (it.wr)
          check(dev_mem.exists(it.a) && dev_mem[it.a] == it.d, "R4",
                "byte stored by write", dev_mem.exists(it.a) ? int'(dev_mem[it.a]) : -1, int'(it.d));
        else
          check(resp_rdata == it.d, "R3", "read data", int'(resp_rdata), int'(it.d));
      end
    end
  end

  // strobe timing monitor
  int oe_lo = 0, oe_hi = 100, we_lo = 0, setup_c = 0, hold_c = 0;
  bit prev_oe = 1'b1, prev_we = 1'b1, prev_dq = 1'b0, in_hold = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_oe_n && !prev_oe)
        check(oe_lo == EXP_RD, "R3", "read strobe cycles (R8 rounding)", oe_lo, EXP_RD);
      if (mem_dq_oe && !prev_dq)
        check(oe_hi >= EXP_REL, "R6", "float cycles before drive", oe_hi, EXP_REL);
      if (!mem_we_n && prev_we) begin
        check(setup_c == EXP_AS, "R5", "drive cycles before write pulse", setup_c, EXP_AS);
        check(!mem_cs_n, "R4", "chip select at write pulse", int'(mem_cs_n), 0);
        check(mem_oe_n, "R9", "output enable during write pulse", int'(mem_oe_n), 1);
      end
      if (mem_we_n && !prev_we)
        check(we_lo == EXP_WP, "R4", "write pulse cycles (R8 rounding)", we_lo, EXP_WP);
      if (!mem_dq_oe && prev_dq)
        check(hold_c == EXP_HOLD, "R5", "drive cycles after write pulse", hold_c, EXP_HOLD);

      oe_lo = mem_oe_n ? 0 : oe_lo + 1;
      oe_hi = mem_oe_n ? oe_hi + 1 : 0;
      we_lo = mem_we_n ? 0 : we_lo + 1;
      if (mem_dq_oe && !prev_dq) begin
        setup_c = 0;
        hold_c  = 0;
        in_hold = 1'b0;
      end
      if (mem_dq_oe && mem_we_n && !in_hold) setup_c++;
      if (mem_we_n && !prev_we) in_hold = 1'b1;
      if (mem_dq_oe && in_hold) hold_c++;
      prev_oe = mem_oe_n;
      prev_we = mem_we_n;
      prev_dq = mem_dq_oe;
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  // watchdog
  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!finished) begin
      check(1'b0, "R7", "watchdog expired", 0, 1);
      summary();
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(mem_cs_n && mem_oe_n && mem_we_n, "R1", "strobes high in reset",
          {mem_cs_n, mem_oe_n, mem_we_n}, 7);
    check(!mem_dq_oe, "R1", "bus released in reset", int'(mem_dq_oe), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(req_ready == 1'b1, "R7", "ready after reset", int'(req_ready), 1);
    check(mem_cs_n && !mem_dq_oe, "R2", "standby after reset", int'(mem_cs_n), 1);

    // writes at boundary addresses and patterns
    do_req(1'b1, 19'h00000, 8'h00);
    do_req(1'b1, 19'h7FFFF, 8'hFF);
    do_req(1'b1, 19'h12345, 8'hA5);
    do_req(1'b1, 19'h54321, 8'h5A);
    // reads back, issued while busy
    do_req(1'b0, 19'h00000, 8'h00);
    do_req(1'b0, 19'h7FFFF, 8'h00);
    do_req(1'b0, 19'h12345, 8'h00);
    // read directly followed by write: bus turnaround
    do_req(1'b0, 19'h54321, 8'h00);
    do_req(1'b1, 19'h54321, 8'hC3);
    do_req(1'b0, 19'h54321, 8'h00);
    // overwrite then read
    do_req(1'b1, 19'h12345, 8'h3C);
    do_req(1'b0, 19'h12345, 8'h00);
    do_req(1'b0, 19'h00000, 8'h00);

    repeat (40) @(negedge clk);
    check(sb_q.size() == 0, "R7", "outstanding items after drain", sb_q.size(), 0);
    check(n_resp == n_req, "R7", "one response per request", n_resp, n_req);
    check(held_cycles > 0, "R7", "requests held off while busy", held_cycles, 1);
    check(req_ready && mem_cs_n && !mem_dq_oe, "R2", "standby when idle",
          {req_ready, mem_cs_n, mem_dq_oe}, 6);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule